// File: doc/BRIEF.md
# Two-Cell Pack Protection Switch Controller

This block is the decision core of a protector for a battery pack of two series cells. Upstream comparators and timers deliver the status of each cell and pack-level flags. From them the block picks how the pack's series disconnect switch is driven. The switch can be held closed, held open, or pulsed at a high or low on-fraction while a charger is attached. The block also drives a flag that asks the rest of the chip to drop into a low-power sleep.

All inputs are plain level signals sampled on the clock. The chosen mode is registered, so it appears one clock after the inputs that cause it. The pulsed gate output is built from that registered mode and a free-running phase counter. Two conditions are held in state. A short-circuit event keeps the switch open until the load is seen to be gone. A sleep entered with no charger attached persists until a charger appears.

Top module: `batt_guard_ctrl`

## Requirements
- R1: Each cell status is a 2-bit code: 00 over-discharged, 01 normal, 10 overcharged, 11 reserved and handled as over-discharged. The mode output uses 00 open, 01 closed, 10 high-duty pulsing, 11 low-duty pulsing, and it takes the value chosen from the inputs sampled at the previous rising edge. With both cells normal and no fault, the mode is closed.
- R2: A short flag opens the switch at the next edge. The switch stays open after the flag drops, until an edge that samples the load-removed flag with no short present. The mode is free to close one edge after that.
- R3: A reversed charger opens the switch.
- R4: An open center tap opens the switch, unless the pack is undervoltage with a charger present, in which case the mode is low-duty pulsing.
- R5: A pack undervoltage with a charger present gives low-duty pulsing. Without a charger it gives open and sets the sleep flag.
- R6: An over-discharged cell with a charger present gives high-duty pulsing. Without a charger it gives open and sets the sleep flag.
- R7: Once set, the sleep flag stays set and the switch stays open while no charger is present, even if the cells read normal. An edge that samples the charger present clears the flag.
- R8: With an overcharged cell and no charger, the switch is closed. With a charger, it stays closed until the delay-timer open request is high, which opens it.
- R9: Conditions are ranked in this order: short (live or held), reversed charger, open tap, undervoltage, over-discharge, held sleep, overcharge, normal.
- R10: The phase counter counts 0 to PERIOD-1 and wraps, advancing on every edge after reset. The gate is high in the closed mode and low in the open mode. In high-duty pulsing the gate is low only in phase PERIOD-1. In low-duty pulsing the gate is high only in phase 0.
- R11: During reset the mode is open, the sleep flag is low, the gate is low and the held short is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_cell | input | 2 | Status code of the upper cell |
| lo_cell | input | 2 | Status code of the lower cell |
| pack_uv | input | 1 | Whole-pack undervoltage |
| chg_present | input | 1 | Charger detected |
| chg_reversed | input | 1 | Charger connected with reversed polarity |
| tap_open | input | 1 | Center tap disconnected |
| short_det | input | 1 | Load current above the trip level |
| load_gone | input | 1 | Pack negative back near cell ground |
| oc_expire | input | 1 | Overcharge grace time elapsed |
| sw_mode | output | 2 | Registered switch mode |
| sw_gate | output | 1 | Switch gate drive after pulsing |
| shutdown | output | 1 | Low-power sleep request |

## Verification
Every combination of the two cell codes is swept against every combination of undervoltage, charger, tap, reversal and timer request. Cases with two or more faults show whether the ranking is right. Cases with a single fault show the mode that fault alone selects. The sweep carries the sleep state from one case to the next, so a normal reading that follows a no-charger fault tests the held sleep. Separate sequences hold the short flag, then drop it, then raise load-removed. These show the latch and its one-edge release. Long runs in each pulsing mode compare the gate against the expected phase for every value the phase counter takes.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;
  typedef enum logic [1:0] {
    CELL_LOW  = 2'b00,
    CELL_OK   = 2'b01,
    CELL_HIGH = 2'b10,
    CELL_RSVD = 2'b11
  } cell_code_e;

  typedef enum logic [1:0] {
    SW_OPEN  = 2'b00,
    SW_CLOSE = 2'b01,
    SW_HI_DUTY = 2'b10,
    SW_LO_DUTY = 2'b11
  } sw_mode_e;

  function automatic logic cell_is_low(input logic [1:0] c);
    return (c == CELL_LOW) || (c == CELL_RSVD);
  endfunction
endpackage

// File: rtl/bg_short_latch.sv
module bg_short_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic short_det,
  input  logic load_gone,
  output logic held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= short_det | (held & ~load_gone);
  end

  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !load_gone) |=> held);
  assert_latch_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    short_det |=> held);
endmodule

// File: rtl/bg_mode_select.sv
module bg_mode_select
  import batt_guard_pkg::*;
(
  input  logic [1:0] hi_cell,
  input  logic [1:0] lo_cell,
  input  logic       pack_uv,
  input  logic       chg_present,
  input  logic       chg_reversed,
  input  logic       tap_open,
  input  logic       oc_expire,
  input  logic       short_any,
  input  logic       sleep_held,
  output sw_mode_e   mode_nxt,
  output logic       sleep_req
);
  logic any_low, any_high;
  assign any_low  = cell_is_low(hi_cell) | cell_is_low(lo_cell);
  assign any_high = (hi_cell == CELL_HIGH) | (lo_cell == CELL_HIGH);

  always_comb begin
    mode_nxt  = SW_CLOSE;
    sleep_req = 1'b0;
    if (short_any) begin
      mode_nxt = SW_OPEN;
    end else if (chg_reversed) begin
      mode_nxt = SW_OPEN;
    end else if (tap_open) begin
      mode_nxt = (pack_uv && chg_present) ? SW_LO_DUTY : SW_OPEN;
    end else if (pack_uv) begin
      mode_nxt  = chg_present ? SW_LO_DUTY : SW_OPEN;
      sleep_req = ~chg_present;
    end else if (any_low) begin
      mode_nxt  = chg_present ? SW_HI_DUTY : SW_OPEN;
      sleep_req = ~chg_present;
    end else if (sleep_held && !chg_present) begin
      mode_nxt = SW_OPEN;
    end else if (any_high) begin
      mode_nxt = (chg_present && oc_expire) ? SW_OPEN : SW_CLOSE;
    end
  end
endmodule

// File: rtl/bg_duty_gen.sv
module bg_duty_gen
  import batt_guard_pkg::*;
#(
  parameter int PERIOD = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sw_mode_e mode,
  output logic     gate
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  always_comb begin
    unique case (mode)
      SW_OPEN:    gate = 1'b0;
      SW_CLOSE:   gate = 1'b1;
      SW_HI_DUTY: gate = (phase != LAST);
      SW_LO_DUTY: gate = (phase == '0);
      default:    gate = 1'b0;
    endcase
  end

  assert_phase_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LAST) |=> (phase == '0));
  assert_phase_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != LAST) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/batt_guard_ctrl.sv
module batt_guard_ctrl
  import batt_guard_pkg::*;
#(
  parameter int PERIOD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hi_cell,
  input  logic [1:0] lo_cell,
  input  logic       pack_uv,
  input  logic       chg_present,
  input  logic       chg_reversed,
  input  logic       tap_open,
  input  logic       short_det,
  input  logic       load_gone,
  input  logic       oc_expire,
  output logic [1:0] sw_mode,
  output logic       sw_gate,
  output logic       shutdown
);
  logic     short_held;
  sw_mode_e mode_nxt, mode_q;
  logic     sleep_req, sleep_q;

  bg_short_latch u_latch (
    .clk(clk), .rst_n(rst_n), .short_det(short_det),
    .load_gone(load_gone), .held(short_held)
  );

  bg_mode_select u_sel (
    .hi_cell(hi_cell), .lo_cell(lo_cell), .pack_uv(pack_uv),
    .chg_present(chg_present), .chg_reversed(chg_reversed),
    .tap_open(tap_open), .oc_expire(oc_expire),
    .short_any(short_det | short_held), .sleep_held(sleep_q),
    .mode_nxt(mode_nxt), .sleep_req(sleep_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SW_OPEN;
      sleep_q <= 1'b0;
    end else begin
      mode_q  <= mode_nxt;
      sleep_q <= chg_present ? 1'b0 : (sleep_q | sleep_req);
    end
  end

  bg_duty_gen #(.PERIOD(PERIOD)) u_duty (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .gate(sw_gate)
  );

  assign sw_mode  = mode_q;
  assign shutdown = sleep_q;

  assert_short_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    short_det |=> (sw_mode == SW_OPEN));
  assert_reverse_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chg_reversed |=> (sw_mode == SW_OPEN));
  assert_tap_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_open && !(pack_uv && chg_present)) |=> (sw_mode == SW_OPEN));
  assert_charger_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_present |=> !shutdown);
  assert_sleep_keeps_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (sw_mode == SW_OPEN || $past(chg_present)));
  assert_open_no_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode == SW_OPEN) |-> !sw_gate);
endmodule

// File: tb/batt_guard_ctrl_tb.sv
module batt_guard_ctrl_tb_top;
  localparam int PERIOD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] hi_cell = 2'b01, lo_cell = 2'b01;
  logic pack_uv = 0, chg_present = 0, chg_reversed = 0, tap_open = 0;
  logic short_det = 0, load_gone = 0, oc_expire = 0;
  logic [1:0] sw_mode;
  logic sw_gate, shutdown;

  int n_checks = 0, n_errors = 0;
  int m_mode = 0, m_sleep = 0, m_held = 0, edges = 0;

  always #2 clk = ~clk;

  batt_guard_ctrl #(.PERIOD(PERIOD)) dut_i (
    .clk(clk), .rst_n(rst_n), .hi_cell(hi_cell), .lo_cell(lo_cell),
    .pack_uv(pack_uv), .chg_present(chg_present), .chg_reversed(chg_reversed),
    .tap_open(tap_open), .short_det(short_det), .load_gone(load_gone),
    .oc_expire(oc_expire), .sw_mode(sw_mode), .sw_gate(sw_gate),
    .shutdown(shutdown)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit low_code(input logic [1:0] c);
    return (c == 2'b00) || (c == 2'b11);
  endfunction

  // expected mode per ranking; code: 0 open 1 closed 2 high-duty 3 low-duty
  function automatic int ref_mode(output int req, output string tag);
    bit sh = short_det | (m_held != 0);
    req = 0;
    if (sh) begin tag = "R2"; return 0; end
    if (chg_reversed) begin tag = "R3"; return 0; end
    if (tap_open) begin tag = "R4"; return (pack_uv && chg_present) ? 3 : 0; end
    if (pack_uv) begin tag = "R5"; req = !chg_present; return chg_present ? 3 : 0; end
    if (low_code(hi_cell) || low_code(lo_cell)) begin
      tag = "R6"; req = !chg_present; return chg_present ? 2 : 0;
    end
    if (m_sleep != 0 && !chg_present) begin tag = "R7"; return 0; end
    if (hi_cell == 2'b10 || lo_cell == 2'b10) begin
      tag = "R8"; return (chg_present && oc_expire) ? 0 : 1;
    end
    tag = "R1";
    return 1;
  endfunction

  task automatic step(input string force_tag);
    int req, ph, eg;
    string tag;
    @(posedge clk);
    m_mode  = ref_mode(req, tag);
    m_sleep = chg_present ? 0 : ((m_sleep != 0 || req != 0) ? 1 : 0);
    m_held  = (short_det || (m_held != 0 && !load_gone)) ? 1 : 0;
    edges++;
    @(negedge clk);
    if (force_tag != "") tag = force_tag;
    chk(tag, int'(sw_mode), m_mode);
    chk("R7", int'(shutdown), m_sleep);
    ph = edges % PERIOD;
    case (m_mode)
      0: eg = 0;
      1: eg = 1;
      2: eg = (ph != PERIOD - 1) ? 1 : 0;
      default: eg = (ph == 0) ? 1 : 0;
    endcase
    chk("R10", int'(sw_gate), eg);
  endtask

  task automatic quiet();
    hi_cell = 2'b01; lo_cell = 2'b01; pack_uv = 0; chg_present = 0;
    chg_reversed = 0; tap_open = 0; short_det = 0; load_gone = 0; oc_expire = 0;
  endtask

  initial begin
    #600000;
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", int'(sw_mode), 0);
    chk("R11", int'(shutdown), 0);
    chk("R11", int'(sw_gate), 0);
    rst_n = 1'b1;

    step("R1");
    // full sweep of cells against flag combinations
    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++)
        for (int f = 0; f < 32; f++) begin
          hi_cell = 2'(h); lo_cell = 2'(l);
          pack_uv = f[0]; chg_present = f[1]; tap_open = f[2];
          chg_reversed = f[3]; oc_expire = f[4];
          step("");
        end

    // R7: held sleep with normal cells and no charger
    quiet(); lo_cell = 2'b00; step("R6");
    lo_cell = 2'b01; repeat (3) step("R7");
    chg_present = 1; step("R7");
    chg_present = 0; step("R1");

    // R2: short latch and release
    short_det = 1; step("R2");
    short_det = 0; repeat (4) step("R2");
    load_gone = 1; step("R2");
    load_gone = 0; step("R2");
    step("R2");
    // short wins over charger with overcharge (R9)
    chg_present = 1; hi_cell = 2'b10; short_det = 1; step("R9");
    short_det = 0; load_gone = 1; step("R9");
    load_gone = 0; step("R8");
    oc_expire = 1; step("R8");

    // R10: whole periods in each pulsing mode
    quiet(); chg_present = 1; lo_cell = 2'b00;
    repeat (3 * PERIOD) step("R10");
    lo_cell = 2'b01; pack_uv = 1;
    repeat (3 * PERIOD) step("R10");
    pack_uv = 1; tap_open = 1; step("R4");
    chg_present = 0; step("R4");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule